// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. It keeps three selector registers, one each for code, data and stack accesses. Each translation request names an access kind, and that kind picks the selector to use. Bit 2 of that selector chooses either the global or the local descriptor table. The index field then picks an 8-byte entry in the chosen table. The block reads the entry over a 64-bit read port with a request/valid handshake.

From the fetched descriptor the block takes a 32-bit base, a 20-bit limit and a granularity bit. It forms the effective limit, either in byte units or in 4 KB units, and compares the offset against it. If the offset is within the limit, it reports base plus offset. If not, it raises a fault and gives no address. Only one translation is in flight at a time, and the result is marked by a one-cycle done strobe.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `done`, `fault`, `mem_req` and `busy` are 0, and `lin_addr` and `mem_addr` are 0.
- R2: The access kind picks the selector register: 0 is code, 1 is data, 2 is stack, and 3 acts as data. The same code on `sel_wr_kind` with `sel_wr_en` high loads that register with `sel_wr_val`.
- R3: A selector holds its index in bits 15:3, the table choice in bit 2 (0 = global, 1 = local) and a requested-privilege field in bits 1:0. The fetch address is the chosen table base plus index times 8. It is valid on `mem_addr` from the cycle after the request is accepted.
- R4: `mem_req` rises in the cycle after the request is accepted. It stays high, with `mem_addr` stable, until `mem_valid` is seen. `done` is then high for exactly one cycle, the cycle after `mem_valid`, and `mem_req` is low in that cycle.
- R5: The descriptor word holds the base in bits 31:0, the limit in bits 51:32 and the granularity bit in bit 55. When the offset is within the effective limit, `lin_addr` equals base plus offset modulo 2^32, and `fault` is 0.
- R6: With granularity 0, the effective limit is the limit itself, in bytes. An offset equal to the limit passes, and an offset one above it faults.
- R7: With granularity 1, the effective limit is the limit shifted left by 12 with the low 12 bits set to 1. An offset equal to that value passes, and one above it faults.
- R8: A fault is reported as `fault` high together with `done`, and `lin_addr` is 0 in that cycle.
- R9: A request presented while a translation is in flight (`busy` high) is ignored. It starts no fetch and does not change the result of the translation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr_en | input | 1 | Load a selector register |
| sel_wr_kind | input | 2 | Which selector register to load (access kind code) |
| sel_wr_val | input | 16 | Selector value to load |
| gdt_base | input | 32 | Base address of the global descriptor table |
| ldt_base | input | 32 | Base address of the local descriptor table |
| req_valid | input | 1 | Start a translation (accepted when not busy) |
| req_kind | input | 2 | Access kind: 0 code, 1 data, 2 stack, 3 data |
| req_offset | input | 32 | Offset within the segment |
| busy | output | 1 | Translation in flight |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_valid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 64 | Descriptor word |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Limit violation, valid with done |
| lin_addr | output | 32 | Linear address, valid with done |

## Verification
The handshake assertions assume that the memory side raises `mem_valid` only while `mem_req` is high, and holds it for a single cycle per request. The bench drives `mem_valid` for exactly one cycle, and only after it has seen `mem_req` high, with a latency of zero to three cycles. The bench also leaves the table bases and selector registers unchanged while a fetch is outstanding, so the fetch address it expects is fixed for the whole wait.

// File: rtl/seg_pkg.sv
// Package: shared types and decode helpers for the segment translator.
// Assumes a 64-bit descriptor word with base [31:0], limit [51:32], gran [55].
package seg_pkg;
    localparam int SEL_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int LIM_W   = 20;
    localparam int DESC_W  = 64;
    localparam int GRAN_SH = 12;
    localparam int N_SEL   = 3;
    localparam int GRAN_BIT = 55;

    localparam logic [1:0] KIND_CODE  = 2'd0;
    localparam logic [1:0] KIND_DATA  = 2'd1;
    localparam logic [1:0] KIND_STACK = 2'd2;

    typedef struct packed {
        logic              gran;
        logic [LIM_W-1:0]  limit;
        logic [ADDR_W-1:0] base;
    } seg_desc_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} seg_state_t;

    // Pull the used fields out of a raw descriptor word.
    function automatic seg_desc_t desc_unpack(input logic [DESC_W-1:0] w);
        seg_desc_t d;
        d.base  = w[ADDR_W-1:0];
        d.limit = w[ADDR_W+LIM_W-1:ADDR_W];
        d.gran  = w[GRAN_BIT];
        return d;
    endfunction

    // Map an access kind code onto a selector slot (code 3 shares the data slot).
    function automatic logic [1:0] kind_slot(input logic [1:0] k);
        return (k == 2'd3) ? KIND_DATA : k;
    endfunction
endpackage

// File: rtl/seg_selbank.sv
// Module: seg_selbank
// Holds one selector register per access kind and reads one out by kind.
// Assumes kind code 3 aliases the data slot.
module seg_selbank
    import seg_pkg::*;
#(
    parameter int W = SEL_W,
    parameter int N = N_SEL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_kind,
    input  logic [W-1:0] wr_val,
    input  logic [1:0]   rd_kind,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] sel_q [N];
    logic [1:0]   wr_slot;
    logic [1:0]   rd_slot;

    assign wr_slot = kind_slot(wr_kind);
    assign rd_slot = kind_slot(rd_kind);

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Load slot g when a write targets it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[g] <= '0;
            else if (wr_en && wr_slot == 2'(g))
                sel_q[g] <= wr_val;
        end
    end

    // Read the slot chosen by the request kind.
    always_comb begin
        rd_val = sel_q[0];
        for (int i = 1; i < N; i++)
            if (rd_slot == 2'(i)) rd_val = sel_q[i];
    end
endmodule

// File: rtl/seg_limit.sv
// Module: seg_limit
// Scales a descriptor limit by its granularity bit, compares the offset with
// it and forms base + offset. Purely combinational.
module seg_limit
    import seg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LIM_W,
    parameter int SH = GRAN_SH
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] limit,
    input  logic          gran,
    input  logic [AW-1:0] offset,
    output logic          over,
    output logic [AW-1:0] sum
);
    localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << SH) - 64'd1);
    logic [AW-1:0] lim_ext;
    logic [AW-1:0] eff_lim;

    // Widen the limit, then scale it to 4 KB units when gran is set.
    always_comb begin
        lim_ext = {{(AW-LW){1'b0}}, limit};
        eff_lim = gran ? ((lim_ext << SH) | LOW_ONES) : lim_ext;
        over    = offset > eff_lim;
        sum     = base + offset;
    end
endmodule

// File: rtl/seg_ctrl.sv
// Module: seg_ctrl
// Sequences one translation: accepts a request, issues the descriptor read,
// waits for the data and registers the result with a one-cycle done strobe.
// Assumes mem_valid only arrives while mem_req is high.
module seg_ctrl
    import seg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_offset,
    input  logic [SW-1:0] sel,
    input  logic [AW-1:0] gdt_base,
    input  logic [AW-1:0] ldt_base,
    input  logic          mem_valid,
    input  logic          chk_over,
    input  logic [AW-1:0] chk_sum,
    output logic [AW-1:0] off_q,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] lin_addr
);
    seg_state_t    state;
    logic [AW-1:0] tbl_base;
    logic [AW-1:0] idx_off;

    // Choose the table by the selector's table bit and scale the index by 8.
    always_comb begin
        tbl_base = sel[2] ? ldt_base : gdt_base;
        idx_off  = {{(AW-SW){1'b0}}, sel[SW-1:3], 3'b000};
    end

    assign busy = (state == ST_FETCH);

    // Step the request/fetch/result sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            off_q    <= '0;
            done     <= 1'b0;
            fault    <= 1'b0;
            lin_addr <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    mem_req  <= 1'b1;
                    mem_addr <= tbl_base + idx_off;
                    off_q    <= req_offset;
                    state    <= ST_FETCH;
                end
                ST_FETCH: if (mem_valid) begin
                    mem_req  <= 1'b0;
                    done     <= 1'b1;
                    fault    <= chk_over;
                    lin_addr <= chk_over ? '0 : chk_sum;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Module: seg_xlate (top)
// Logical-to-linear translator: selector bank, fetch controller and limit
// check. One translation at a time; descriptor read over a request/valid port.
module seg_xlate
    import seg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_wr_en,
    input  logic [1:0]  sel_wr_kind,
    input  logic [15:0] sel_wr_val,
    input  logic [31:0] gdt_base,
    input  logic [31:0] ldt_base,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [31:0] req_offset,
    output logic        busy,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_valid,
    input  logic [63:0] mem_rdata,
    output logic        done,
    output logic        fault,
    output logic [31:0] lin_addr
);
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W-1:0] chk_sum;
    logic              chk_over;
    seg_desc_t         desc;

    assign desc = desc_unpack(mem_rdata);

    seg_selbank #(.W(SEL_W), .N(N_SEL)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sel_wr_en), .wr_kind(sel_wr_kind), .wr_val(sel_wr_val),
        .rd_kind(req_kind), .rd_val(sel)
    );

    seg_limit #(.AW(ADDR_W), .LW(LIM_W), .SH(GRAN_SH)) u_lim (
        .base(desc.base), .limit(desc.limit), .gran(desc.gran),
        .offset(off_q), .over(chk_over), .sum(chk_sum)
    );

    seg_ctrl #(.AW(ADDR_W), .SW(SEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_offset(req_offset), .sel(sel),
        .gdt_base(gdt_base), .ldt_base(ldt_base),
        .mem_valid(mem_valid), .chk_over(chk_over), .chk_sum(chk_sum),
        .off_q(off_q), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .done(done), .fault(fault), .lin_addr(lin_addr)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
// Module: seg_xlate_chk
// Protocol checker bound to seg_xlate. Assumes mem_valid is a single-cycle
// pulse given only while mem_req is high.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid,
    input logic        done,
    input logic        fault,
    input logic [31:0] lin_addr
);
    // R4: the read request holds until data arrives.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> mem_req);
    // R3: the fetch address stays put while waiting.
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> $stable(mem_addr));
    // R4: data arrival gives done next cycle with the request dropped.
    assert_done_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (done && !mem_req));
    // R4: done is a single-cycle strobe.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a fault comes with done and a zero address.
    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && lin_addr == 32'd0));
    // R9: an outstanding request is always a busy translator.
    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .done(done),
    .fault(fault), .lin_addr(lin_addr)
);

// File: tb/sim_seg_xlate.sv
// Bench for seg_xlate: a vector table walked by one loop, then directed tests.
module sim_seg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr_en = 1'b0;
    logic [1:0]  sel_wr_kind = '0;
    logic [15:0] sel_wr_val = '0;
    logic [31:0] gdt_base = 32'h0001_0000;
    logic [31:0] ldt_base = 32'h0002_0000;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_offset = '0;
    logic        busy, mem_req, done, fault;
    logic [31:0] mem_addr, lin_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    seg_xlate u0 (
        .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_kind(sel_wr_kind),
        .sel_wr_val(sel_wr_val), .gdt_base(gdt_base), .ldt_base(ldt_base),
        .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .lin_addr(lin_addr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] off;
        logic [31:0] base;
        logic [19:0] lim;
        logic        g;
        logic [1:0]  lat;
        logic [31:0] exp_lin;
        logic        exp_flt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h0000_0100, 32'h0040_0000, 20'h00FFF, 1'b0, 2'd0, 32'h0040_0100, 1'b0},
        '{2'd1, 32'h0001_2345, 32'h1000_0000, 20'h12345, 1'b0, 2'd1, 32'h1001_2345, 1'b0},
        '{2'd1, 32'h0001_2346, 32'h1000_0000, 20'h12345, 1'b0, 2'd2, 32'h0000_0000, 1'b1},
        '{2'd2, 32'h7FFF_FFFF, 32'h0000_0000, 20'h7FFFF, 1'b1, 2'd3, 32'h7FFF_FFFF, 1'b0},
        '{2'd2, 32'h8000_0000, 32'h0000_0000, 20'h7FFFF, 1'b1, 2'd0, 32'h0000_0000, 1'b1},
        '{2'd0, 32'hFFFF_FFFF, 32'h0000_0010, 20'hFFFFF, 1'b1, 2'd1, 32'h0000_000F, 1'b0},
        '{2'd0, 32'h0000_0FFF, 32'hABC0_0000, 20'h00000, 1'b1, 2'd2, 32'hABC0_0FFF, 1'b0},
        '{2'd3, 32'h0000_1000, 32'hABC0_0000, 20'h00000, 1'b1, 2'd0, 32'h0000_0000, 1'b1},
        '{2'd1, 32'h0000_0000, 32'h0000_1234, 20'h00000, 1'b0, 2'd3, 32'h0000_1234, 1'b0}
    };

    // Fetch address expected for each kind with the selectors loaded below (R2, R3).
    function automatic logic [31:0] exp_addr(input logic [1:0] k);
        case (k)
            2'd0:    return 32'h0001_0010; // code: index 2, global
            2'd2:    return 32'h0001_0028; // stack: index 5, global
            default: return 32'h0002_0018; // data: index 3, local, rpl 3
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic load_sel(input logic [1:0] k, input logic [15:0] v);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_kind = k; sel_wr_val = v;
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int i);
        @(negedge clk);
        req_kind = v.kind; req_offset = v.off; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req === 1'b1, $sformatf("R4 req raised v%0d", i), {31'd0, mem_req}, 32'd1);
        check(mem_addr === exp_addr(v.kind), $sformatf("R2/R3 fetch address v%0d", i),
              mem_addr, exp_addr(v.kind));
        for (int w = 0; w < int'(v.lat); w++) begin
            @(negedge clk);
            check(mem_req === 1'b1 && done === 1'b0, $sformatf("R4 hold v%0d", i),
                  {31'd0, mem_req}, 32'd1);
        end
        mem_rdata = {8'h00, v.g, 3'b000, v.lim, v.base};
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        check(done === 1'b1 && mem_req === 1'b0, $sformatf("R4 done v%0d", i),
              {31'd0, done}, 32'd1);
        check(fault === v.exp_flt, $sformatf("R6/R7 fault v%0d", i),
              {31'd0, fault}, {31'd0, v.exp_flt});
        check(lin_addr === v.exp_lin, $sformatf("R5/R8 linear v%0d", i), lin_addr, v.exp_lin);
        @(negedge clk);
        check(done === 1'b0, $sformatf("R4 done pulse v%0d", i), {31'd0, done}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done === 0 && fault === 0 && mem_req === 0 && busy === 0,
              "R1 reset flags", {28'd0, done, fault, mem_req, busy}, 32'd0);
        check(lin_addr === 0 && mem_addr === 0, "R1 reset addresses", lin_addr | mem_addr, 32'd0);
        rst_n = 1'b1;
        load_sel(2'd0, 16'h0010);
        load_sel(2'd1, 16'h001F);
        load_sel(2'd2, 16'h0028);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R9: a second request during a fetch is ignored.
        @(negedge clk);
        req_kind = 2'd0; req_offset = 32'h20; req_valid = 1'b1;
        @(negedge clk);
        req_kind = 2'd2; req_offset = 32'h999;
        check(busy === 1'b1, "R9 busy in flight", {31'd0, busy}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_addr === 32'h0001_0010, "R9 address unchanged", mem_addr, 32'h0001_0010);
        mem_rdata = {8'h00, 1'b0, 3'b000, 20'h00100, 32'h0000_5000};
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        check(done === 1'b1 && lin_addr === 32'h0000_5020, "R9 first result kept",
              lin_addr, 32'h0000_5020);
        repeat (3) begin
            @(negedge clk);
            check(mem_req === 1'b0 && busy === 1'b0, "R9 no extra fetch",
                  {31'd0, mem_req}, 32'd0);
        end

        // R2: reloading the stack selector moves the stack fetch to the local table.
        load_sel(2'd2, 16'h0044);
        @(negedge clk);
        req_kind = 2'd2; req_offset = 32'h0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_addr === 32'h0002_0040, "R2/R3 reloaded stack selector", mem_addr, 32'h0002_0040);
        mem_rdata = {8'h00, 1'b0, 3'b000, 20'h00000, 32'h0000_0000};
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
        @(negedge clk);
        finish_up();
    end
endmodule